// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one atomic memory instruction at a time against a simple synchronous memory port. A pulse on `start` presents an 8-bit opcode and a 32-bit immediate. The opcode must select the atomic mode of the store-from-register class at either 4-byte or 8-byte width. The immediate names the sub-operation. The unit also takes the base address register value, a 16-bit offset, the source register value and the current R0 value. The unit first reads the addressed location. It then computes the new value and writes it back unless a compare-exchange misses. Finally it presents the register writebacks for one cycle together with a `done` strobe.

A `mem_lock` output stays high from the read request through the write request, so that outside arbitration can hold other masters off the location for the whole sequence. The memory must return read data in the cycle after a read request. An opcode or immediate that the unit does not support produces a one-cycle `error` strobe and no memory traffic. All outputs come from registers.

Top module: `atomic_rmw_unit`

## Requirements
- R1: An opcode is accepted only when it is 0xC3 (atomic mode 0b110 in bits 7:5, 4-byte size 0b00 in bits 4:3, class 0b011 in bits 2:0) or 0xDB (the same with 8-byte size 0b11). Any other opcode, including the 1-byte and 2-byte sizes, raises `error` for exactly one cycle, starting the cycle after `start`, and issues no memory request and no lock.
- R2: The immediate is accepted only with bits 31:8 and 3:1 all zero. Bits 7:4 select the sub-operation: 0x0 add, 0x4 or, 0x5 and, 0xA xor, 0xE exchange, 0xF compare-exchange. Bit 0 is the fetch flag, and it is mandatory for exchange and compare-exchange. Any other immediate raises the same one-cycle `error` as R1 and issues no memory access.
- R3: The memory address is the base address plus the offset sign-extended to the address width, wrapping at the address width. It stays unchanged from the read request through the write request.
- R4: For an accepted instruction, the read request (`mem_req`=1, `mem_we`=0) appears in the cycle after `start`. Then comes one modify cycle with no request. Then the write request (`mem_req`=1, `mem_we`=1) appears if one is due. `done` follows for exactly one cycle. `mem_lock` is high exactly from the read cycle through the cycle before `done`.
- R5: Add, or, and and xor combine the old memory value with the source register value and write the result. For 4-byte instructions, only bits 31:0 of both operands take part, the result wraps at 32 bits, `mem_dword` is 0, and the write data is zero-extended. For 8-byte instructions, `mem_dword` is 1.
- R6: With the fetch flag set, an add, or, and or xor writes the old memory value back to the source register in the `done` cycle (zero-extended for 4-byte instructions). Without the flag, neither writeback enable rises.
- R7: Exchange writes the source register value to memory and writes the old memory value back to the source register.
- R8: Compare-exchange compares the old memory value with R0, over 32 bits for 4-byte instructions and 64 bits for 8-byte instructions. On a match it writes the source register value to memory. On a miss it issues no write, and `done` follows the modify cycle directly. In both cases R0 receives the old value (zero-extended for 4-byte instructions) and the source register receives nothing.
- R9: `start` and all operand inputs are ignored while `busy` is high. `busy` is high from the cycle after an accepted or rejected `start` until the `done` or `error` cycle has ended.
- R10: After reset, `mem_req`, `mem_we`, `mem_lock`, `done`, `error`, `busy` and both writeback enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches the instruction presented on the operand inputs |
| opcode | input | 8 | Instruction opcode byte |
| imm | input | 32 | Immediate carrying the sub-operation and fetch flag |
| base_addr | input | ADDR_W | Destination (base address) register value |
| offset | input | OFF_W | Signed address offset |
| src_val | input | DATA_W | Source register value |
| r0_val | input | DATA_W | R0 value used by compare-exchange |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_dword | output | 1 | 1 = 8-byte access, 0 = 4-byte access on bits 31:0 |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| mem_lock | output | 1 | Holds the location for the whole read-then-write sequence |
| src_wb_en | output | 1 | Source register writeback enable |
| src_wb_data | output | DATA_W | Source register writeback value |
| r0_wb_en | output | 1 | R0 writeback enable |
| r0_wb_data | output | DATA_W | R0 writeback value |
| done | output | 1 | One-cycle completion strobe |
| error | output | 1 | One-cycle unsupported-instruction strobe |
| busy | output | 1 | Unit is occupied and ignores `start` |

## Verification
Two situations are hard to reach from the ports. The first is a compare-exchange that hinges only on which bits are compared. The bench reaches it by computing R0 from the model's memory image at issue time. It supplies an exact copy for a match, a bitwise complement for a miss, and, for a 4-byte instruction, a value whose upper half differs while the lower half matches, which must still count as a match. The second is a new `start` arriving mid-sequence. The bench reaches it by raising `start` again during the read and modify cycles, with an illegal opcode and a changed source value, and it then expects the original write data and no error strobe.

// File: rtl/atomic_pkg.sv
// Shared encodings and types for the atomic read-modify-write unit.
// Assumes opcode layout: mode in bits 7:5, size in bits 4:3, class in bits 2:0.
package atomic_pkg;

    localparam logic [2:0] MODE_ATOMIC    = 3'b110;
    localparam logic [2:0] CLASS_STORE_RG = 3'b011;
    localparam logic [1:0] SIZE_WORD      = 2'b00;
    localparam logic [1:0] SIZE_DWORD     = 2'b11;

    localparam logic [3:0] SUB_ADD   = 4'h0;
    localparam logic [3:0] SUB_OR    = 4'h4;
    localparam logic [3:0] SUB_AND   = 4'h5;
    localparam logic [3:0] SUB_XOR   = 4'hA;
    localparam logic [3:0] SUB_SWAP  = 4'hE;
    localparam logic [3:0] SUB_CSWAP = 4'hF;

    typedef enum logic [2:0] {
        AOP_ADD,
        AOP_OR,
        AOP_AND,
        AOP_XOR,
        AOP_SWAP,
        AOP_CSWAP
    } aop_e;

    typedef struct packed {
        logic legal;
        logic dword;
        aop_e op;
        logic fetch;
    } adec_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_MODIFY,
        ST_WRITE,
        ST_DONE,
        ST_FAULT
    } seq_e;

endpackage

// File: rtl/atomic_decode.sv
// Instruction decoder: classifies opcode and immediate into a sub-operation.
// Assumes nothing about timing; purely combinational.
module atomic_decode
    import atomic_pkg::*;
(
    input  logic [7:0]  opcode,
    input  logic [31:0] imm,
    output adec_t       dec
);

    logic opc_ok;
    logic imm_clean;
    logic sub_ok;
    aop_e sub_op;

    // Opcode must be the atomic mode of the register store class at 4 or 8 bytes.
    always_comb begin
        opc_ok = (opcode[7:5] == MODE_ATOMIC) && (opcode[2:0] == CLASS_STORE_RG) &&
                 ((opcode[4:3] == SIZE_WORD) || (opcode[4:3] == SIZE_DWORD));
    end

    // Reserved immediate bits must be clear.
    always_comb begin
        imm_clean = (imm[31:8] == 24'h0) && (imm[3:1] == 3'b000);
    end

    // Map the sub-operation nibble; swap forms demand the fetch flag.
    always_comb begin
        sub_ok = 1'b1;
        sub_op = AOP_ADD;
        case (imm[7:4])
            SUB_ADD:   sub_op = AOP_ADD;
            SUB_OR:    sub_op = AOP_OR;
            SUB_AND:   sub_op = AOP_AND;
            SUB_XOR:   sub_op = AOP_XOR;
            SUB_SWAP:  begin sub_op = AOP_SWAP;  sub_ok = imm[0]; end
            SUB_CSWAP: begin sub_op = AOP_CSWAP; sub_ok = imm[0]; end
            default:   sub_ok = 1'b0;
        endcase
    end

    // Assemble the decoded record.
    always_comb begin
        dec.legal = opc_ok && imm_clean && sub_ok;
        dec.dword = (opcode[4:3] == SIZE_DWORD);
        dec.op    = sub_op;
        dec.fetch = imm[0];
    end

endmodule

// File: rtl/atomic_addr_gen.sv
// Effective address generator: base plus sign-extended offset, wrapping.
// Assumes ADDR_W is larger than OFF_W.
module atomic_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);

    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;

    // Sign-extend the offset to the address width.
    always_comb begin
        off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
    end

    // Add with natural wrap at the address width.
    always_comb begin
        addr = base + off_ext;
    end

endmodule

// File: rtl/atomic_alu.sv
// Modify stage: combines the old memory word with the latched operands.
// Assumes old_raw is the raw memory read data; narrows to the low half for 4-byte ops.
module atomic_alu
    import atomic_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  aop_e              op,
    input  logic              dword,
    input  logic [DATA_W-1:0] old_raw,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] cmp_val,
    output logic [DATA_W-1:0] old_ext,
    output logic [DATA_W-1:0] new_val,
    output logic              write_ok
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] width_mask;
    logic [DATA_W-1:0] opnd_m;
    logic [DATA_W-1:0] cmp_m;
    logic [DATA_W-1:0] raw_res;

    // Select the active width mask.
    always_comb begin
        width_mask = dword ? {DATA_W{1'b1}} : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    end

    // Narrow all operands to the active width.
    always_comb begin
        old_ext = old_raw & width_mask;
        opnd_m  = operand & width_mask;
        cmp_m   = cmp_val & width_mask;
    end

    // Compute the candidate value for the selected sub-operation.
    always_comb begin
        case (op)
            AOP_ADD: raw_res = old_ext + opnd_m;
            AOP_OR:  raw_res = old_ext | opnd_m;
            AOP_AND: raw_res = old_ext & opnd_m;
            AOP_XOR: raw_res = old_ext ^ opnd_m;
            default: raw_res = opnd_m;
        endcase
        new_val = raw_res & width_mask;
    end

    // A write is due unless a compare-exchange misses.
    always_comb begin
        write_ok = (op != AOP_CSWAP) || (old_ext == cmp_m);
    end

endmodule

// File: rtl/atomic_seq.sv
// Sequencer: IDLE -> READ -> MODIFY -> (WRITE) -> DONE, or IDLE -> FAULT.
// Assumes read data arrives during MODIFY; start is only honoured in IDLE.
module atomic_seq
    import atomic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic legal,
    input  logic write_ok,
    output seq_e state
);

    seq_e state_nx;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (start) state_nx = legal ? ST_READ : ST_FAULT;
            ST_READ:   state_nx = ST_MODIFY;
            ST_MODIFY: state_nx = write_ok ? ST_WRITE : ST_DONE;
            ST_WRITE:  state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            ST_FAULT:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/atomic_rmw_unit.sv
// Top of the atomic read-modify-write unit. Latches operands on an accepted
// start, reads the location, computes, conditionally writes, then strobes done
// with register writebacks. Assumes a memory that returns read data the cycle
// after a read request and accepts a write in the cycle it is requested.
module atomic_rmw_unit
    import atomic_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [31:0]       imm,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] r0_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_dword,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_lock,
    output logic              src_wb_en,
    output logic [DATA_W-1:0] src_wb_data,
    output logic              r0_wb_en,
    output logic [DATA_W-1:0] r0_wb_data,
    output logic              done,
    output logic              error,
    output logic              busy
);

    adec_t             dec;
    adec_t             dec_q;
    seq_e              state;
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] r0_q;
    logic [DATA_W-1:0] old_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] old_ext;
    logic [DATA_W-1:0] new_val;
    logic              write_ok;
    logic              accept;

    atomic_decode u_decode (
        .opcode (opcode),
        .imm    (imm),
        .dec    (dec)
    );

    atomic_addr_gen #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_addr (
        .base   (base_addr),
        .offset (offset),
        .addr   (eff_addr)
    );

    atomic_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op       (dec_q.op),
        .dword    (dec_q.dword),
        .old_raw  (mem_rdata),
        .operand  (src_q),
        .cmp_val  (r0_q),
        .old_ext  (old_ext),
        .new_val  (new_val),
        .write_ok (write_ok)
    );

    atomic_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .legal    (dec.legal),
        .write_ok (write_ok),
        .state    (state)
    );

    // An instruction is taken only in IDLE and only when legal.
    always_comb begin
        accept = (state == ST_IDLE) && start && dec.legal;
    end

    // Capture the decoded instruction and its operands at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q  <= '0;
            addr_q <= '0;
            src_q  <= '0;
            r0_q   <= '0;
        end else if (accept) begin
            dec_q  <= dec;
            addr_q <= eff_addr;
            src_q  <= src_val;
            r0_q   <= r0_val;
        end
    end

    // Register the old value and the computed value at the end of MODIFY.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_q   <= '0;
            wdata_q <= '0;
        end else if (state == ST_MODIFY) begin
            old_q   <= old_ext;
            wdata_q <= new_val;
        end
    end

    // Memory port driven from state and captured registers only.
    always_comb begin
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_lock  = (state == ST_READ) || (state == ST_MODIFY) || (state == ST_WRITE);
        mem_dword = dec_q.dword;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
    end

    // Completion, fault and writeback outputs.
    always_comb begin
        done        = (state == ST_DONE);
        error       = (state == ST_FAULT);
        busy        = (state != ST_IDLE);
        src_wb_en   = done && ((dec_q.op == AOP_SWAP) ||
                               (dec_q.fetch && (dec_q.op != AOP_CSWAP)));
        r0_wb_en    = done && (dec_q.op == AOP_CSWAP);
        src_wb_data = old_q;
        r0_wb_data  = old_q;
    end

endmodule

// Protocol checker for atomic_rmw_unit, attached by bind below.
// Assumes it observes only ports of the unit.
module atomic_rmw_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_lock,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic              error,
    input logic              src_wb_en,
    input logic              r0_wb_en
);

    assert_req_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);

    assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $past(mem_req && !mem_we, 2));

    assert_lock_drops_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_lock);

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && $past(mem_lock)) |-> $stable(mem_addr));

    assert_fault_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!mem_req && !mem_lock && !done));

    assert_fault_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);

    assert_wb_only_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wb_en || r0_wb_en) |-> done);

    assert_cswap_no_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r0_wb_en |-> !src_wb_en);

endmodule

bind atomic_rmw_unit atomic_rmw_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_lock  (mem_lock),
    .mem_addr  (mem_addr),
    .done      (done),
    .error     (error),
    .src_wb_en (src_wb_en),
    .r0_wb_en  (r0_wb_en)
);

// File: tb/atomic_rmw_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle reference model fed through queues,
// compared against the unit's ports on every falling edge.
module atomic_rmw_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic [31:0] imm_i = '0;
    logic [31:0] base_i = '0;
    logic [15:0] off_i = '0;
    logic [63:0] src_i = '0;
    logic [63:0] r0_i = '0;
    logic        mem_req, mem_we, mem_dword, mem_lock;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        src_wb_en, r0_wb_en, done, error, busy;
    logic [63:0] src_wb_data, r0_wb_data;

    int n_checks = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;

    typedef struct packed {
        bit req; bit we; bit lock; bit dn; bit err; bit bsy;
        bit src_en; bit r0_en; bit dw;
        logic [31:0] addr;
        logic [63:0] wdata;
        logic [63:0] src_d;
        logic [63:0] r0_d;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    logic [63:0] ref_mem [logic [31:0]];
    logic [63:0] phys_mem [logic [31:0]];

    always #5 clk = ~clk;

    atomic_rmw_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start_i), .opcode(opcode_i), .imm(imm_i),
        .base_addr(base_i), .offset(off_i), .src_val(src_i), .r0_val(r0_i),
        .mem_req(mem_req), .mem_we(mem_we), .mem_dword(mem_dword), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_lock(mem_lock),
        .src_wb_en(src_wb_en), .src_wb_data(src_wb_data), .r0_wb_en(r0_wb_en),
        .r0_wb_data(r0_wb_data), .done(done), .error(error), .busy(busy)
    );

    // Synchronous memory: read data one cycle after request; 4-byte writes keep bits 63:32.
    always @(posedge clk) begin
        if (mem_req && !mem_we) begin
            mem_rdata <= phys_mem.exists(mem_addr) ? phys_mem[mem_addr] : 64'h0;
        end else if (mem_req && mem_we) begin
            if (mem_dword) phys_mem[mem_addr] = mem_wdata;
            else phys_mem[mem_addr] = {(phys_mem.exists(mem_addr) ? phys_mem[mem_addr][63:32] : 32'h0),
                                       mem_wdata[31:0]};
        end
    end

    function automatic logic [63:0] ref_rd(input logic [31:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : 64'h0;
    endfunction

    task automatic preload(input logic [31:0] a, input logic [63:0] v);
        ref_mem[a] = v;
        phys_mem[a] = v;
    endtask

    task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", r, what, act, expv, $time);
        end
    endtask

    // Per-cycle comparison against the model's expected record.
    always @(negedge clk) begin
        exp_t  e;
        string t;
        if (mon_on) begin
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
            end else begin
                e = '0;
                t = "R10";
            end
            chk("R4", "mem_req", 64'(mem_req), 64'(e.req));
            chk("R4", "mem_we", 64'(mem_we), 64'(e.we));
            chk("R4", "mem_lock", 64'(mem_lock), 64'(e.lock));
            chk("R4", "done", 64'(done), 64'(e.dn));
            chk(t, "error", 64'(error), 64'(e.err));
            chk("R9", "busy", 64'(busy), 64'(e.bsy));
            chk(t, "src_wb_en", 64'(src_wb_en), 64'(e.src_en));
            chk(t, "r0_wb_en", 64'(r0_wb_en), 64'(e.r0_en));
            if (e.req) begin
                chk("R3", "mem_addr", 64'(mem_addr), 64'(e.addr));
                chk("R5", "mem_dword", 64'(mem_dword), 64'(e.dw));
            end
            if (e.we)     chk(t, "mem_wdata", mem_wdata, e.wdata);
            if (e.src_en) chk(t, "src_wb_data", src_wb_data, e.src_d);
            if (e.r0_en)  chk(t, "r0_wb_data", r0_wb_data, e.r0_d);
        end
    end

    function automatic bit imm_legal(input logic [31:0] im);
        case (im)
            32'h00, 32'h01, 32'h40, 32'h41, 32'h50, 32'h51,
            32'ha0, 32'ha1, 32'he1, 32'hf1: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Issue one instruction and queue the expected per-cycle outputs.
    task automatic run_op(input logic [7:0] opc, input logic [31:0] im, input logic [31:0] base,
                          input logic [15:0] off, input logic [63:0] sv, input logic [63:0] rv,
                          input string tag, input bit poke);
        exp_t e;
        logic [31:0] a;
        logic [63:0] msk, old_full, old, s, c, nv;
        bit dw, wr, legal;
        @(posedge clk); #2;
        opcode_i = opc; imm_i = im; base_i = base; off_i = off; src_i = sv; r0_i = rv;
        start_i = 1'b1;
        e = '0;
        exp_q.push_back(e); tag_q.push_back("R9");
        legal = ((opc == 8'hc3) || (opc == 8'hdb)) && imm_legal(im);
        if (!legal) begin
            e = '0; e.err = 1; e.bsy = 1;
            exp_q.push_back(e); tag_q.push_back(tag);
        end else begin
            dw = (opc == 8'hdb);
            a = base + {{16{off[15]}}, off};
            msk = dw ? 64'hffff_ffff_ffff_ffff : 64'h0000_0000_ffff_ffff;
            old_full = ref_rd(a);
            old = old_full & msk; s = sv & msk; c = rv & msk;
            case (im[7:4])
                4'h0: nv = (old + s) & msk;
                4'h4: nv = old | s;
                4'h5: nv = old & s;
                4'ha: nv = old ^ s;
                default: nv = s;
            endcase
            wr = (im[7:4] != 4'hf) || (old == c);
            e = '0; e.req = 1; e.lock = 1; e.bsy = 1; e.addr = a; e.dw = dw;
            exp_q.push_back(e); tag_q.push_back(tag);
            e = '0; e.lock = 1; e.bsy = 1;
            exp_q.push_back(e); tag_q.push_back(tag);
            if (wr) begin
                e = '0; e.req = 1; e.we = 1; e.lock = 1; e.bsy = 1; e.addr = a; e.dw = dw; e.wdata = nv;
                exp_q.push_back(e); tag_q.push_back(tag);
                ref_mem[a] = dw ? nv : {old_full[63:32], nv[31:0]};
            end
            e = '0; e.dn = 1; e.bsy = 1;
            e.src_en = (im[7:4] == 4'he) || (im[0] && (im[7:4] != 4'hf));
            e.src_d = old;
            e.r0_en = (im[7:4] == 4'hf);
            e.r0_d = old;
            exp_q.push_back(e); tag_q.push_back(tag);
        end
        @(posedge clk); #2;
        start_i = 1'b0;
        if (poke) begin
            start_i = 1'b1; opcode_i = 8'h00; imm_i = 32'hffff_ffff; src_i = ~sv; base_i = ~base;
            repeat (2) begin @(posedge clk); #2; end
            start_i = 1'b0;
        end
        while (exp_q.size() != 0) begin @(posedge clk); #2; end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #1000000;
        n_fail++;
        $display("FAIL R4 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        logic [63:0] cur;
        preload(32'h100, 64'h0000_0001_ffff_fff0);
        preload(32'h200, 64'h1234_5678_9abc_def0);
        preload(32'h0f0, 64'haaaa_5555_0f0f_f0f0);
        preload(32'h210, 64'hcafe_f00d_ffff_00ff);
        repeat (3) @(posedge clk);
        #2; rst_n = 1'b1;
        @(posedge clk); #2; mon_on = 1'b1;
        // R10: outputs quiet after reset (monitor compares idle records).
        repeat (2) begin @(posedge clk); #2; end

        // R5: 4-byte add wraps at 32 bits, upper memory half untouched, no writeback.
        run_op(8'hc3, 32'h00, 32'h0f0, 16'h0010, 64'hffff_0000_0000_0020, 64'h0, "R5", 1'b0);
        // R6: 8-byte add with fetch, carry into upper half.
        run_op(8'hdb, 32'h01, 32'h100, 16'h0000, 64'h0000_0000_ffff_fff0, 64'h0, "R6", 1'b0);
        run_op(8'hdb, 32'h41, 32'h200, 16'h0000, 64'h0f00_0000_0000_000f, 64'h0, "R6", 1'b0);
        // R3: negative offset.
        run_op(8'hc3, 32'h50, 32'h220, 16'hfff0, 64'h0000_0000_0f0f_0f0f, 64'h0, "R3", 1'b0);
        run_op(8'hdb, 32'ha1, 32'h200, 16'h0000, 64'hffff_0000_ffff_0000, 64'h0, "R5", 1'b0);
        run_op(8'hc3, 32'h51, 32'h1f8, 16'h0008, 64'h1111_1111_00ff_00ff, 64'h0, "R6", 1'b0);
        run_op(8'hc3, 32'ha0, 32'h210, 16'h0000, 64'h0000_0000_1234_4321, 64'h0, "R5", 1'b0);
        // R3: address wrap at 32 bits.
        run_op(8'hdb, 32'h40, 32'hffff_fff8, 16'h0010, 64'h5, 64'h0, "R3", 1'b0);
        // R7: exchange at both sizes.
        run_op(8'hc3, 32'he1, 32'h0f0, 16'h0000, 64'hdead_beef_0bad_f00d, 64'h0, "R7", 1'b0);
        run_op(8'hdb, 32'he1, 32'h0f0, 16'h0000, 64'h0123_4567_89ab_cdef, 64'h0, "R7", 1'b0);
        // R8: compare-exchange match, miss, and 4-byte match with differing upper R0 half.
        cur = ref_rd(32'h200);
        run_op(8'hdb, 32'hf1, 32'h200, 16'h0000, 64'h7777_0000_0000_7777, cur, "R8", 1'b0);
        cur = ref_rd(32'h200);
        run_op(8'hdb, 32'hf1, 32'h200, 16'h0000, 64'h9999_9999_9999_9999, ~cur, "R8", 1'b0);
        cur = ref_rd(32'h100);
        run_op(8'hc3, 32'hf1, 32'h100, 16'h0000, 64'h0000_0000_abcd_abcd,
               {~cur[63:32], cur[31:0]}, "R8", 1'b0);
        cur = ref_rd(32'h100);
        run_op(8'hc3, 32'hf1, 32'h100, 16'h0000, 64'h1, {cur[63:32], ~cur[31:0]}, "R8", 1'b0);
        // R1: unsupported opcodes (byte, half, wrong class, wrong mode).
        run_op(8'hd3, 32'h00, 32'h100, 16'h0, 64'h1, 64'h0, "R1", 1'b0);
        run_op(8'hcb, 32'h01, 32'h100, 16'h0, 64'h1, 64'h0, "R1", 1'b0);
        run_op(8'hc2, 32'h00, 32'h100, 16'h0, 64'h1, 64'h0, "R1", 1'b0);
        run_op(8'h7b, 32'h00, 32'h100, 16'h0, 64'h1, 64'h0, "R1", 1'b0);
        // R2: unsupported immediates.
        run_op(8'hc3, 32'h80, 32'h100, 16'h0, 64'h1, 64'h0, "R2", 1'b0);
        run_op(8'hdb, 32'he0, 32'h100, 16'h0, 64'h1, 64'h0, "R2", 1'b0);
        run_op(8'hdb, 32'hf0, 32'h100, 16'h0, 64'h1, 64'h0, "R2", 1'b0);
        run_op(8'hc3, 32'h02, 32'h100, 16'h0, 64'h1, 64'h0, "R2", 1'b0);
        run_op(8'hc3, 32'h100, 32'h100, 16'h0, 64'h1, 64'h0, "R2", 1'b0);
        // R9: start and operands changed mid-sequence are ignored.
        run_op(8'hdb, 32'h01, 32'h210, 16'h0000, 64'h0000_0003_0000_0003, 64'h0, "R9", 1'b1);
        run_op(8'hdb, 32'hf1, 32'h0f0, 16'h0000, 64'h4444, ref_rd(32'h0f0), "R9", 1'b1);
        // Final image check of the locations touched through the memory port.
        chk("R5", "mem[0x100]", phys_mem[32'h100], ref_rd(32'h100));
        chk("R7", "mem[0x0f0]", phys_mem[32'h0f0], ref_rd(32'h0f0));
        chk("R8", "mem[0x200]", phys_mem[32'h200], ref_rd(32'h200));
        chk("R9", "mem[0x210]", phys_mem[32'h210], ref_rd(32'h210));
        repeat (3) begin @(posedge clk); #2; end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule